// File: doc/BRIEF.md
# Configurable Multilevel Pipeline Register

This block holds four data stages, called A1, A2, B1 and B2. All four are fed from one shared data input. On each rising clock edge a 2-bit operation code sets how the stages move. They can act as one four-deep chain. They can act as a two-deep A chain or a two-deep B chain, and in that case the other pair keeps its contents. The last choice is to freeze all four stages.

A 2-bit read select picks any one stage and routes it to the output through combinational logic, so a stage can be read at any time with no clock edge. An active-low output enable controls the output. The block provides a plain data/valid pair (`y_data`, `y_oe`) for logic on the same chip, and a three-state bus port that floats while the enable is released.

The "state" of the block is the operation code, decoded each cycle into one of four named modes:
- `OP_CHAIN4`: the four-deep chain.
- `OP_PAIR_B`: the B pair shifts.
- `OP_PAIR_A`: the A pair shifts.
- `OP_HOLD`: nothing moves.

There are no stored transitions between modes. Every edge obeys whichever mode is applied at that edge.

Top module: `mlpipe_reg`

## Requirements
- R1: While `rst` is high at a rising edge, all four stages become zero. Reset takes priority over every operation code.
- R2: Code 0 (`OP_CHAIN4`) shifts every stage on the same edge: `din` goes to A1, A1 to A2, A2 to B1, and B1 to B2.
- R3: Code 1 (`OP_PAIR_B`) loads `din` into B1 and moves the old B1 into B2. A1 and A2 keep their values.
- R4: Code 2 (`OP_PAIR_A`) loads `din` into A1 and moves the old A1 into A2. B1 and B2 keep their values.
- R5: Code 3 (`OP_HOLD`) leaves all four stages unchanged across the edge, whatever `din` is.
- R6: `sel` picks the stage shown on `y_data`: 2'b11 shows A1, 2'b10 shows A2, 2'b01 shows B1 and 2'b00 shows B2. A change of `sel` appears with no clock edge.
- R7: When `oe_n` is high, `y_oe` is 0 and `y_bus` is high-impedance. When `oe_n` is low, `y_oe` is 1 and `y_bus` carries `y_data`. The enable does not change any stage.
- R8: Stages change only at a rising edge. A change of `din` or `op` between edges leaves every stage as it was until the next edge, and that edge obeys the code applied at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stages update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 2 | Operation code (0 chain4, 1 pair B, 2 pair A, 3 hold) |
| din | input | W (8) | Shared data input |
| sel | input | 2 | Read select for the output |
| oe_n | input | 1 | Active-low output enable |
| y_data | output | W (8) | Selected stage, not gated by the enable |
| y_oe | output | 1 | High when the bus is driven |
| y_bus | output | W (8) | Three-state output bus |

## Verification
The bench keeps all four stages distinct and reads every stage back after each edge. A design that wires the chain in the wrong order, or that lets the idle pair drift in a two-deep mode, shows a wrong stage value at once. It also switches the operation code and the data between edges. A design that latches the code or the data too early, or that shifts on the wrong edge, fails those reads. The select codes are swept with no clock edge, which catches a reversed or registered multiplexer. The enable is toggled to show that it gates only the bus and never the stored contents.

// File: rtl/mlpipe_pkg.sv
package mlpipe_pkg;

    typedef enum logic [1:0] {
        OP_CHAIN4 = 2'd0,
        OP_PAIR_B = 2'd1,
        OP_PAIR_A = 2'd2,
        OP_HOLD   = 2'd3
    } op_e;

    localparam int NUM_STAGES = 4;
    localparam int SEL_W      = $clog2(NUM_STAGES);

    localparam int STG_A1 = 0;
    localparam int STG_A2 = 1;
    localparam int STG_B1 = 2;
    localparam int STG_B2 = 3;

endpackage

// File: rtl/mlpipe_decode.sv
module mlpipe_decode
    import mlpipe_pkg::*;
(
    input  logic [1:0]            op,
    output logic [NUM_STAGES-1:0] load_en,
    output logic                  b1_from_din
);

    op_e mode;

    always_comb begin
        mode        = op_e'(op);
        load_en     = '0;
        b1_from_din = 1'b0;
        unique case (mode)
            OP_CHAIN4: begin
                load_en = '1;
            end
            OP_PAIR_B: begin
                load_en[STG_B1] = 1'b1;
                load_en[STG_B2] = 1'b1;
                b1_from_din     = 1'b1;
            end
            OP_PAIR_A: begin
                load_en[STG_A1] = 1'b1;
                load_en[STG_A2] = 1'b1;
            end
            OP_HOLD: begin
                load_en = '0;
            end
            default: begin
                load_en = '0;
            end
        endcase
    end

endmodule

// File: rtl/mlpipe_stage.sv
module mlpipe_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/mlpipe_outmux.sv
module mlpipe_outmux
    import mlpipe_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [NUM_STAGES-1:0][W-1:0] stage_q,
    input  logic [SEL_W-1:0]             sel,
    input  logic                         oe_n,
    output logic [W-1:0]                 y_data,
    output logic                         y_oe
);

    localparam logic [SEL_W-1:0] TOP_IDX = SEL_W'(NUM_STAGES - 1);

    logic [SEL_W-1:0] idx;

    always_comb begin
        idx    = TOP_IDX - sel;
        y_data = stage_q[idx];
        y_oe   = ~oe_n;
    end

endmodule

// File: rtl/mlpipe_reg.sv
module mlpipe_reg
    import mlpipe_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           op,
    input  logic [W-1:0]         din,
    input  logic [SEL_W-1:0]     sel,
    input  logic                 oe_n,
    output logic [W-1:0]         y_data,
    output logic                 y_oe,
    output logic [W-1:0]         y_bus
);

    logic [NUM_STAGES-1:0]        load_en;
    logic                         b1_from_din;
    logic [NUM_STAGES-1:0][W-1:0] stage_d;
    logic [NUM_STAGES-1:0][W-1:0] stage_q;
    logic [W-1:0]                 a1_q;
    logic [W-1:0]                 a2_q;
    logic [W-1:0]                 b1_q;
    logic [W-1:0]                 b2_q;

    mlpipe_decode u_decode (
        .op          (op),
        .load_en     (load_en),
        .b1_from_din (b1_from_din)
    );

    always_comb begin
        stage_d[STG_A1] = din;
        stage_d[STG_A2] = stage_q[STG_A1];
        stage_d[STG_B1] = b1_from_din ? din : stage_q[STG_A2];
        stage_d[STG_B2] = stage_q[STG_B1];
    end

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        mlpipe_stage #(.W(W)) u_stage (
            .clk  (clk),
            .rst  (rst),
            .load (load_en[g]),
            .d    (stage_d[g]),
            .q    (stage_q[g])
        );
    end

    assign a1_q = stage_q[STG_A1];
    assign a2_q = stage_q[STG_A2];
    assign b1_q = stage_q[STG_B1];
    assign b2_q = stage_q[STG_B2];

    mlpipe_outmux #(.W(W)) u_outmux (
        .stage_q (stage_q),
        .sel     (sel),
        .oe_n    (oe_n),
        .y_data  (y_data),
        .y_oe    (y_oe)
    );

    assign y_bus = y_oe ? y_data : {W{1'bz}};

endmodule

// File: rtl/mlpipe_chk.sv
module mlpipe_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [1:0]   op,
    input logic [W-1:0] din,
    input logic [1:0]   sel,
    input logic         oe_n,
    input logic [W-1:0] a1_q,
    input logic [W-1:0] a2_q,
    input logic [W-1:0] b1_q,
    input logic [W-1:0] b2_q,
    input logic [W-1:0] y_data,
    input logic         y_oe
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (a1_q == '0 && a2_q == '0 && b1_q == '0 && b2_q == '0));

    // R2
    chain4_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (op == 2'd0) |=> (a1_q == $past(din) && a2_q == $past(a1_q) &&
                          b1_q == $past(a2_q) && b2_q == $past(b1_q)));

    // R3
    pair_b_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (op == 2'd1) |=> (b1_q == $past(din) && b2_q == $past(b1_q) &&
                          $stable(a1_q) && $stable(a2_q)));

    // R4
    pair_a_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (op == 2'd2) |=> (a1_q == $past(din) && a2_q == $past(a1_q) &&
                          $stable(b1_q) && $stable(b2_q)));

    // R5
    hold_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (op == 2'd3) |=> ($stable(a1_q) && $stable(a2_q) &&
                          $stable(b1_q) && $stable(b2_q)));

    // R6
    sel_route_chk: assert property (@(posedge clk) disable iff (rst)
        ((sel == 2'b11) |-> (y_data == a1_q)) and
        ((sel == 2'b10) |-> (y_data == a2_q)) and
        ((sel == 2'b01) |-> (y_data == b1_q)) and
        ((sel == 2'b00) |-> (y_data == b2_q)));

    // R7
    enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !y_oe);

endmodule

bind mlpipe_reg mlpipe_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .din    (din),
    .sel    (sel),
    .oe_n   (oe_n),
    .a1_q   (a1_q),
    .a2_q   (a2_q),
    .b1_q   (b1_q),
    .b2_q   (b2_q),
    .y_data (y_data),
    .y_oe   (y_oe)
);

// File: tb/mlpipe_reg_bench.sv
`timescale 1ns/100ps
module mlpipe_reg_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   op;
    logic [W-1:0] din;
    logic [1:0]   sel;
    logic         oe_n;
    logic [W-1:0] y_data;
    logic         y_oe;
    logic [W-1:0] y_bus;

    int checks   = 0;
    int failures = 0;

    // model: index 0=A1 1=A2 2=B1 3=B2
    logic [W-1:0] m [4];

    always #4 clk = ~clk;

    mlpipe_reg #(.W(W)) u_mlpipe_reg (
        .clk(clk), .rst(rst), .op(op), .din(din), .sel(sel),
        .oe_n(oe_n), .y_data(y_data), .y_oe(y_oe), .y_bus(y_bus)
    );

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // sel code for model index i is 3-i
    task automatic read_all(input string tag);
        for (int i = 0; i < 4; i++) begin
            sel = 2'(3 - i);
            #0.5;
            chk(tag, y_data, m[i]);
        end
    endtask

    task automatic step(input logic r, input logic [1:0] o, input logic [W-1:0] d);
        @(negedge clk);
        rst = r; op = o; din = d;
        @(posedge clk);
        if (r) begin
            for (int i = 0; i < 4; i++) m[i] = '0;
        end else begin
            case (o)
                2'd0: begin m[3] = m[2]; m[2] = m[1]; m[1] = m[0]; m[0] = d; end
                2'd1: begin m[3] = m[2]; m[2] = d; end
                2'd2: begin m[1] = m[0]; m[0] = d; end
                default: ;
            endcase
        end
        #1;
    endtask

    task automatic t_reset();
        step(1'b0, 2'd0, 8'hAA);
        step(1'b1, 2'd0, 8'h5C);
        read_all("R1 reset clears stages");
    endtask

    task automatic t_chain();
        step(1'b0, 2'd0, 8'h11);
        step(1'b0, 2'd0, 8'h22);
        step(1'b0, 2'd0, 8'h33);
        step(1'b0, 2'd0, 8'h44);
        read_all("R2 chain4 fill");
        step(1'b0, 2'd0, 8'h55);
        read_all("R2 chain4 shift");
    endtask

    task automatic t_pair_b();
        step(1'b0, 2'd1, 8'hB0);
        read_all("R3 pair B first");
        step(1'b0, 2'd1, 8'hB1);
        read_all("R3 pair B second");
    endtask

    task automatic t_pair_a();
        step(1'b0, 2'd2, 8'hA0);
        read_all("R4 pair A first");
        step(1'b0, 2'd2, 8'hA1);
        read_all("R4 pair A second");
    endtask

    task automatic t_hold();
        step(1'b0, 2'd3, 8'hFF);
        step(1'b0, 2'd3, 8'h00);
        read_all("R5 hold keeps stages");
    endtask

    task automatic t_select();
        // each sel code routes its stage with no clock edge
        sel = 2'b11; #0.5; chk("R6 sel 11 shows A1", y_data, m[0]);
        sel = 2'b10; #0.5; chk("R6 sel 10 shows A2", y_data, m[1]);
        sel = 2'b01; #0.5; chk("R6 sel 01 shows B1", y_data, m[2]);
        sel = 2'b00; #0.5; chk("R6 sel 00 shows B2", y_data, m[3]);
    endtask

    task automatic t_enable();
        @(negedge clk);
        op = 2'd3;
        oe_n = 1'b1; sel = 2'b11; #0.5;
        chk("R7 released enable y_oe", W'(y_oe), W'(1'b0));
        oe_n = 1'b0; #0.5;
        chk("R7 asserted enable y_oe", W'(y_oe), W'(1'b1));
        chk("R7 bus carries data", y_bus, m[0]);
        oe_n = 1'b1; #0.5;
        oe_n = 1'b0;
        step(1'b0, 2'd3, 8'h00);
        read_all("R7 enable leaves stages");
    endtask

    task automatic t_midcycle();
        step(1'b0, 2'd0, 8'h61);
        @(negedge clk);
        op = 2'd1; din = 8'h77;
        read_all("R8 no change between edges");
        op = 2'd2; din = 8'h88;
        // edge obeys the late code (pair A) and data
        @(posedge clk);
        m[1] = m[0]; m[0] = 8'h88;
        #1;
        read_all("R8 late code applied");
    endtask

    initial begin
        #(200000 * 8);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; op = 2'd3; din = '0; sel = 2'b00; oe_n = 1'b0;
        for (int i = 0; i < 4; i++) m[i] = '0;
        @(posedge clk);
        #1;
        read_all("R1 initial reset");
        t_reset();
        t_chain();
        t_pair_b();
        t_pair_a();
        t_hold();
        t_select();
        t_enable();
        t_midcycle();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule